// File: doc/BRIEF.md
# Power-Managed Machine-Cycle Divider

This block turns the system clock into a machine-cycle enable for a CPU core. It produces a strobe that is high for one clock per machine cycle. In fast mode a machine cycle is 4 clocks long. In the low-power rate it is 1024 clocks long. Software picks the rate through a single-cycle register write that carries two fields: a slow-rate request and a switchback enable.

When switchback is enabled, either a qualifying external interrupt line or serial-port activity cancels the slow-rate request in hardware. The divider then runs at the fast rate again. A sticky flag records that the return was automatic. A rate change only takes effect when the machine cycle in progress ends, so no cycle is ever cut short. The current rate appears on a status output.

Top module: `mcyc_div`

## Requirements
- R1: After reset, `mc_stb` is high for exactly one clock every 4 clocks, and `slow_mode` is 0.
- R2: While `slow_mode` is 1, the strobe repeats every 1024 clocks and stays high for one clock.
- R3: A write with `wr_en`=1 stores `wr_slow_req` into `pm_req` (visible the clock after the write). `slow_mode` takes the value of `pm_req` only at the clock that follows a strobe, so every interval between strobes is a full 4 or a full 1024 clocks.
- R4: A write with `wr_slow_req`=0 during a slow cycle lets that cycle run its full 1024 clocks. Strobes then return to a 4-clock spacing.
- R5: With switchback enabled, a clock with `ext_irq`=1 clears `pm_req` on the next clock. The slow cycle in progress finishes, and the rate after it is fast.
- R6: With switchback enabled, a clock with `serial_act`=1 has the same effect as in R5.
- R7: `swb_flag` is set when a switchback source fires while `pm_req` or `slow_mode` is 1. It is cleared by any write made without a switchback at the same time. With switchback disabled, `ext_irq` and `serial_act` change neither `pm_req` nor `swb_flag`.
- R8: While switchback is enabled and a source is active, a write with `wr_slow_req`=1 leaves `pm_req` at 0, and the divider stays at the 4-clock rate.
- R9: Reset (`rst` high, synchronous) leaves `pm_req`=0, switchback disabled, `swb_flag`=0, `slow_mode`=0 and `mc_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-clock control register write |
| wr_slow_req | input | 1 | Write field: request the 1024-clock rate |
| wr_swb_en | input | 1 | Write field: enable hardware switchback |
| ext_irq | input | 1 | Qualifying external interrupt, level, synchronous |
| serial_act | input | 1 | Serial-port activity indication, synchronous |
| mc_stb | output | 1 | One-clock machine-cycle strobe |
| slow_mode | output | 1 | 1 while the divider runs at the 1024-clock rate |
| pm_req | output | 1 | Current slow-rate request bit |
| swb_flag | output | 1 | Sticky: an automatic return to the fast rate occurred |

## Verification
The assertions assume that `ext_irq`, `serial_act` and the write fields are already synchronous to `clk`. They also assume that `rst` is held for at least one edge before any property is meaningful. The stimulus changes every input only on the falling clock edge. Source pulses and writes are one clock wide, except in the ignored-write case, where `serial_act` is held across the write on purpose. Writes are placed just after a strobe or deep inside a slow cycle, so the expected boundary for each rate change is never ambiguous.

// File: rtl/mcyc_div_pkg.sv
package mcyc_div_pkg;

    localparam int DEF_FAST_DIV = 4;
    localparam int DEF_SLOW_DIV = 1024;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    typedef struct packed {
        logic slow_req;
        logic swb_en;
    } ctrl_word_t;

    function automatic logic wake_hit(input logic enable, input logic irq, input logic ser);
        return enable & (irq | ser);
    endfunction

endpackage

// File: rtl/mcyc_div_ctrl.sv
module mcyc_div_ctrl
    import mcyc_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_word_t wr_word,
    input  logic       ext_irq,
    input  logic       serial_act,
    input  logic       slow_mode,
    output logic       pm_req,
    output logic       swb_flag
);

    ctrl_word_t ctrl_q;
    logic       flag_q;
    logic       wake;

    assign wake = wake_hit(ctrl_q.swb_en, ext_irq, serial_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en) begin
                ctrl_q.swb_en <= wr_word.swb_en;
            end
            if (wake) begin
                ctrl_q.slow_req <= 1'b0;
            end else if (wr_en) begin
                ctrl_q.slow_req <= wr_word.slow_req;
            end
            if (wake && (ctrl_q.slow_req || slow_mode)) begin
                flag_q <= 1'b1;
            end else if (wr_en) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign pm_req   = ctrl_q.slow_req;
    assign swb_flag = flag_q;

    // R5 R6
    switchback_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.swb_en && (ext_irq || serial_act)) |=> !pm_req);

    // R7
    disabled_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.swb_en && !wr_en) |=> ($stable(pm_req) && $stable(swb_flag)));

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_word.slow_req && ctrl_q.swb_en && serial_act) |=> !pm_req);

endmodule

// File: rtl/mcyc_div_counter.sv
module mcyc_div_counter
    import mcyc_div_pkg::*;
#(
    parameter int FAST_DIV = DEF_FAST_DIV,
    parameter int SLOW_DIV = DEF_SLOW_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic want_slow,
    output logic mc_stb,
    output logic slow_mode
);

    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);

    rate_e         rate_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          at_end;

    assign last   = (rate_q == RATE_SLOW) ? SLOW_LAST : FAST_LAST;
    assign at_end = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            rate_q <= RATE_FAST;
        end else if (at_end) begin
            cnt_q  <= '0;
            rate_q <= want_slow ? RATE_SLOW : RATE_FAST;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign mc_stb    = at_end && !rst;
    assign slow_mode = (rate_q == RATE_SLOW);

    // R1 R2
    stb_width_chk: assert property (@(posedge clk) disable iff (rst)
        mc_stb |=> !mc_stb);

    // R3
    mode_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !mc_stb |=> $stable(slow_mode));

    // R1
    fast_range_chk: assert property (@(posedge clk) disable iff (rst)
        !slow_mode |-> (cnt_q <= FAST_LAST));

endmodule

// File: rtl/mcyc_div.sv
module mcyc_div
    import mcyc_div_pkg::*;
#(
    parameter int FAST_DIV = DEF_FAST_DIV,
    parameter int SLOW_DIV = DEF_SLOW_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_slow_req,
    input  logic wr_swb_en,
    input  logic ext_irq,
    input  logic serial_act,
    output logic mc_stb,
    output logic slow_mode,
    output logic pm_req,
    output logic swb_flag
);

    ctrl_word_t word;

    assign word.slow_req = wr_slow_req;
    assign word.swb_en   = wr_swb_en;

    mcyc_div_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_word    (word),
        .ext_irq    (ext_irq),
        .serial_act (serial_act),
        .slow_mode  (slow_mode),
        .pm_req     (pm_req),
        .swb_flag   (swb_flag)
    );

    mcyc_div_counter #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .want_slow (pm_req),
        .mc_stb    (mc_stb),
        .slow_mode (slow_mode)
    );

endmodule

// File: tb/mcyc_div_bench.sv
module mcyc_div_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FAST = 4;
    localparam int SLOW = 1024;
    localparam int WATCHDOG = 60000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_slow_req = 1'b0, wr_swb_en = 1'b0;
    logic ext_irq = 1'b0, serial_act = 1'b0;
    logic mc_stb, slow_mode, pm_req, swb_flag;

    typedef struct {
        int   period;
        logic mode;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_div u_mcyc_div (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slow_req(wr_slow_req),
        .wr_swb_en(wr_swb_en), .ext_irq(ext_irq), .serial_act(serial_act),
        .mc_stb(mc_stb), .slow_mode(slow_mode), .pm_req(pm_req), .swb_flag(swb_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int period, input logic mode, input string req);
        exp_t e;
        e.period = period;
        e.mode = mode;
        e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: measures strobe spacing and the rate seen at each strobe
    int since = 0;
    always @(negedge clk) begin
        if (rst) begin
            since <= 0;
        end else if (mc_stb) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.req, " period"}, since + 1, e.period);
                chk({e.req, " mode"}, int'(slow_mode), int'(e.mode));
            end
            since <= 0;
        end else begin
            since <= since + 1;
        end
    end

    task automatic wait_stb(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!mc_stb) @(negedge clk);
        end
        #1;
    endtask

    task automatic cfg_write(input logic slow, input logic swb);
        @(negedge clk);
        wr_en = 1'b1; wr_slow_req = slow; wr_swb_en = swb;
        @(negedge clk);
        wr_en = 1'b0; wr_slow_req = 1'b0; wr_swb_en = 1'b0;
    endtask

    task automatic pulse(input logic irq, input logic ser);
        @(negedge clk);
        ext_irq = irq; serial_act = ser;
        @(negedge clk);
        ext_irq = 1'b0; serial_act = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 mc_stb", int'(mc_stb), 0);
        chk("R9 slow_mode", int'(slow_mode), 0);
        chk("R9 pm_req", int'(pm_req), 0);
        chk("R9 swb_flag", int'(swb_flag), 0);
        rst = 1'b0;

        // R1 fast rate
        wait_stb(1);
        push(FAST, 1'b0, "R1"); push(FAST, 1'b0, "R1"); push(FAST, 1'b0, "R1");
        wait_stb(3);

        // R3 request slow right after a strobe: current cycle completes fast
        cfg_write(1'b1, 1'b0);
        chk("R3 pm_req after write", int'(pm_req), 1);
        chk("R3 slow_mode before boundary", int'(slow_mode), 0);
        push(FAST, 1'b0, "R3"); push(SLOW, 1'b1, "R2"); push(SLOW, 1'b1, "R2");
        wait_stb(2);

        // R4 clear mid slow cycle
        repeat (100) @(negedge clk);
        cfg_write(1'b0, 1'b0);
        chk("R4 pm_req cleared", int'(pm_req), 0);
        chk("R4 slow_mode held", int'(slow_mode), 1);
        push(FAST, 1'b0, "R4"); push(FAST, 1'b0, "R4");
        wait_stb(3);

        // R5 interrupt switchback
        cfg_write(1'b1, 1'b1);
        push(FAST, 1'b0, "R5"); push(SLOW, 1'b1, "R5");
        wait_stb(1);
        repeat (200) @(negedge clk);
        pulse(1'b1, 1'b0);
        chk("R5 pm_req cleared", int'(pm_req), 0);
        chk("R7 swb_flag set by irq", int'(swb_flag), 1);
        chk("R5 slow cycle continues", int'(slow_mode), 1);
        push(FAST, 1'b0, "R5"); push(FAST, 1'b0, "R5");
        wait_stb(3);

        // R6 serial switchback; R7 flag cleared by write
        cfg_write(1'b1, 1'b1);
        chk("R7 swb_flag cleared by write", int'(swb_flag), 0);
        push(FAST, 1'b0, "R6"); push(SLOW, 1'b1, "R6");
        wait_stb(1);
        repeat (300) @(negedge clk);
        pulse(1'b0, 1'b1);
        chk("R6 pm_req cleared", int'(pm_req), 0);
        chk("R6 swb_flag set", int'(swb_flag), 1);
        push(FAST, 1'b0, "R6"); push(FAST, 1'b0, "R6");
        wait_stb(3);

        // R7 switchback disabled: sources have no effect
        cfg_write(1'b1, 1'b0);
        push(FAST, 1'b0, "R7"); push(SLOW, 1'b1, "R7"); push(SLOW, 1'b1, "R7");
        wait_stb(1);
        repeat (200) @(negedge clk);
        pulse(1'b1, 1'b1);
        chk("R7 pm_req kept", int'(pm_req), 1);
        chk("R7 swb_flag stays clear", int'(swb_flag), 0);
        wait_stb(2);
        cfg_write(1'b0, 1'b0);
        push(SLOW, 1'b1, "R7"); push(FAST, 1'b0, "R7");
        wait_stb(2);

        // R8 slow request ignored while a source is active
        cfg_write(1'b0, 1'b1);
        @(negedge clk);
        serial_act = 1'b1;
        cfg_write(1'b1, 1'b1);
        chk("R8 pm_req ignored", int'(pm_req), 0);
        chk("R8 swb_flag", int'(swb_flag), 0);
        wait_stb(1);
        push(FAST, 1'b0, "R8"); push(FAST, 1'b0, "R8");
        wait_stb(2);
        serial_act = 1'b0;
        chk("R8 slow_mode", int'(slow_mode), 0);

        chk("queue drained", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule